// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the finite-state controller of a small multicycle processor that executes four classes of 32-bit instructions: register-to-register ALU operations, word loads, word stores and branch-if-equal. It observes the opcode and function fields held in the instruction register, along with the ALU zero flag. In every cycle it drives the full set of datapath control lines: memory strobes, instruction-register and register-file write enables, PC write enables, multiplexer selects, and the ALU operation.

Every instruction begins with a common fetch cycle and a common decode cycle. The decode cycle always prepares a branch target in ALUOut, even when the instruction is not a branch. After decode, each class follows its own path and returns to fetch at its own point. Branches take 3 cycles, ALU operations and stores take 4, and loads take 5. The instruction class is captured during decode, so the opcode input is not examined again until the next decode.

Top module: `mc_ctrl_seq`

## Requirements
- R1: While `rst` is high, `mem_rd`, `mem_wr`, `ir_we`, `pc_we`, `pc_we_cond`, `pc_load` and `rf_we` are all 0 in every cycle. This holds even when reset arrives in the middle of an instruction. The first cycle after `rst` is released is a fetch cycle.
- R2: A fetch cycle drives `mem_rd`=1, `addr_sel`=0 (address from PC), `ir_we`=1, `pc_we`=1, `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=0 (ALU result). All other enables are 0. A fetch cycle is always followed by a decode cycle.
- R3: A decode cycle is identical for every opcode. It drives `alu_a_sel`=0, `alu_b_sel`=11 (sign-extended offset shifted left by 2) and `alu_op`=00, with every enable and strobe at 0.
- R4: For opcode 0x00 (ALU operation), decode is followed by an execute cycle and then a write-back cycle, and the sequence returns to fetch after 4 cycles in total.
  - The execute cycle drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10.
  - The write-back cycle drives `rf_we`=1, `rf_dst_sel`=1 (destination register in bits 15–11) and `rf_wdata_sel`=0 (ALUOut).
- R5: For opcode 0x04 (branch-if-equal), decode is followed by a single compare cycle, and the sequence returns to fetch after 3 cycles. The compare cycle drives:
  - `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=01 (subtract);
  - `pc_we_cond`=1 and `pc_src`=1 (ALUOut);
  - `pc_load` equal to `zero`.
- R6: For loads and stores, decode is followed by an address cycle. It drives `alu_a_sel`=1, `alu_b_sel`=10 (sign-extended immediate) and `alu_op`=00, with no enables.
- R7: For opcode 0x2B (store word), the address cycle is followed by one cycle with `mem_wr`=1 and `addr_sel`=1, and the sequence then returns to fetch, for 4 cycles in total.
- R8: For opcode 0x23 (load word), the address cycle is followed by two cycles before the return to fetch, for 5 cycles in total.
  - A read cycle drives `mem_rd`=1 and `addr_sel`=1.
  - A write-back cycle drives `rf_we`=1, `rf_dst_sel`=0 (bits 20–16) and `rf_wdata_sel`=1 (memory data register).
- R9: Any other opcode returns to fetch directly after decode and performs no write beyond those of fetch.
- R10: `pc_load` is 1 in every fetch cycle whatever the value of `zero`. It follows `zero` in the branch compare cycle, and it is 0 in every other cycle.
- R11: `alu_ctrl` decodes the ALU operation as follows:
  - `alu_op` 00 gives 0010 (add), and 01 gives 0110 (subtract).
  - With `alu_op` 10, the function field selects the operation: 0x20 gives 0010, 0x22 gives 0110, 0x24 gives 0000, 0x25 gives 0001 and 0x2A gives 0111.
  - Any other function code gives 0010.
- R12: The instruction class is latched in the decode cycle. A change of `opcode` after decode does not alter the remaining steps of the instruction.
- R13: `mem_rd` and `mem_wr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register (bits 31–26) |
| funct | input | 6 | Function field of the instruction register (bits 5–0) |
| zero | input | 1 | ALU zero flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address select: 0 = PC, 1 = ALUOut |
| ir_we | output | 1 | Instruction register write enable |
| pc_we | output | 1 | Unconditional PC write enable |
| pc_we_cond | output | 1 | PC write enable qualified by the zero flag |
| pc_load | output | 1 | Combined PC load strobe |
| rf_we | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register: 0 = bits 20–16, 1 = bits 15–11 |
| rf_wdata_sel | output | 1 | Register write data: 0 = ALUOut, 1 = memory data register |
| alu_a_sel | output | 1 | ALU A operand: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B operand: 00 = B, 01 = 4, 10 = immediate, 11 = immediate shifted left by 2 |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |
| pc_src | output | 1 | PC source: 0 = ALU result, 1 = ALUOut |
| alu_ctrl | output | 4 | Decoded ALU operation |

## Verification
Two functions can fall in the same cycle: reset and a cycle in the middle of an instruction that drives a memory or register strobe. The bench raises reset during the read cycle of a load and again during a fetch cycle with `zero` high. It expects every strobe to drop within that same cycle while the selects keep their values, and a clean fetch afterwards. The zero flag is likewise toggled during fetch and during the branch compare, so the unconditional PC write is judged separately from the conditional one.

// File: rtl/mc_ctrl_pkg.sv
`timescale 1ns/1ps
package mc_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_MADDR,
        ST_MREAD,
        ST_LDWB,
        ST_MWRITE,
        ST_REXEC,
        ST_RWB,
        ST_BRANCH
    } step_e;

    typedef enum logic [2:0] {
        CL_ALU,
        CL_LOAD,
        CL_STORE,
        CL_BRANCH,
        CL_NONE
    } cls_e;

    localparam logic [1:0] AOP_ADD  = 2'b00;
    localparam logic [1:0] AOP_SUB  = 2'b01;
    localparam logic [1:0] AOP_FUNC = 2'b10;

    localparam logic [1:0] BSEL_REG  = 2'b00;
    localparam logic [1:0] BSEL_FOUR = 2'b01;
    localparam logic [1:0] BSEL_IMM  = 2'b10;
    localparam logic [1:0] BSEL_OFFS = 2'b11;

    typedef struct packed {
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_sel;
        logic       ir_we;
        logic       pc_we;
        logic       pc_we_cond;
        logic       pc_load;
        logic       rf_we;
        logic       rf_dst_sel;
        logic       rf_wdata_sel;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
        logic       pc_src;
    } ctl_t;

    typedef struct packed {
        step_e step;
        cls_e  cls;
    } seq_t;

endpackage

// File: rtl/mc_op_classify.sv
`timescale 1ns/1ps
module mc_op_classify
    import mc_ctrl_pkg::*;
#(
    parameter int              OP_W       = 6,
    parameter logic [OP_W-1:0] OPC_ALU    = 6'h00,
    parameter logic [OP_W-1:0] OPC_LOAD   = 6'h23,
    parameter logic [OP_W-1:0] OPC_STORE  = 6'h2B,
    parameter logic [OP_W-1:0] OPC_BRANCH = 6'h04
) (
    input  logic [OP_W-1:0] opcode,
    output cls_e            cls
);

    always_comb begin
        if (opcode == OPC_ALU)
            cls = CL_ALU;
        else if (opcode == OPC_LOAD)
            cls = CL_LOAD;
        else if (opcode == OPC_STORE)
            cls = CL_STORE;
        else if (opcode == OPC_BRANCH)
            cls = CL_BRANCH;
        else
            cls = CL_NONE;
    end

endmodule

// File: rtl/mc_seq_state.sv
`timescale 1ns/1ps
module mc_seq_state
    import mc_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cls_e  cls_in,
    output step_e step
);

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.step)
            ST_FETCH:  seq_d.step = ST_DECODE;
            ST_DECODE: begin
                seq_d.cls = cls_in;
                case (cls_in)
                    CL_ALU:             seq_d.step = ST_REXEC;
                    CL_LOAD, CL_STORE:  seq_d.step = ST_MADDR;
                    CL_BRANCH:          seq_d.step = ST_BRANCH;
                    default:            seq_d.step = ST_FETCH;
                endcase
            end
            ST_MADDR:  seq_d.step = (seq_q.cls == CL_LOAD) ? ST_MREAD : ST_MWRITE;
            ST_MREAD:  seq_d.step = ST_LDWB;
            ST_REXEC:  seq_d.step = ST_RWB;
            default:   seq_d.step = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.step <= ST_FETCH;
            seq_q.cls  <= CL_NONE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign step = seq_q.step;

    p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
        (seq_q.step == ST_FETCH) |=> (seq_q.step == ST_DECODE));

    p_rwb_after_exec_r4: assert property (@(posedge clk) disable iff (rst)
        (seq_q.step == ST_RWB) |-> ($past(seq_q.step) == ST_REXEC));

    p_ldwb_after_read_r8: assert property (@(posedge clk) disable iff (rst)
        (seq_q.step == ST_LDWB) |-> ($past(seq_q.step) == ST_MREAD));

    p_noop_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (seq_q.step == ST_DECODE && cls_in == CL_NONE) |=> (seq_q.step == ST_FETCH));

    p_class_held_r12: assert property (@(posedge clk) disable iff (rst)
        (seq_q.step != ST_DECODE) |=> $stable(seq_q.cls));

endmodule

// File: rtl/mc_ctl_drive.sv
`timescale 1ns/1ps
module mc_ctl_drive
    import mc_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  zero,
    input  step_e step,
    output ctl_t  ctl
);

    ctl_t w;

    always_comb begin
        w = '0;
        case (step)
            ST_FETCH: begin
                w.mem_rd    = 1'b1;
                w.ir_we     = 1'b1;
                w.pc_we     = 1'b1;
                w.alu_b_sel = BSEL_FOUR;
                w.alu_op    = AOP_ADD;
            end
            ST_DECODE: begin
                w.alu_b_sel = BSEL_OFFS;
                w.alu_op    = AOP_ADD;
            end
            ST_MADDR: begin
                w.alu_a_sel = 1'b1;
                w.alu_b_sel = BSEL_IMM;
                w.alu_op    = AOP_ADD;
            end
            ST_MREAD: begin
                w.mem_rd   = 1'b1;
                w.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                w.rf_we        = 1'b1;
                w.rf_wdata_sel = 1'b1;
            end
            ST_MWRITE: begin
                w.mem_wr   = 1'b1;
                w.addr_sel = 1'b1;
            end
            ST_REXEC: begin
                w.alu_a_sel = 1'b1;
                w.alu_b_sel = BSEL_REG;
                w.alu_op    = AOP_FUNC;
            end
            ST_RWB: begin
                w.rf_we      = 1'b1;
                w.rf_dst_sel = 1'b1;
            end
            ST_BRANCH: begin
                w.alu_a_sel  = 1'b1;
                w.alu_b_sel  = BSEL_REG;
                w.alu_op     = AOP_SUB;
                w.pc_we_cond = 1'b1;
                w.pc_src     = 1'b1;
            end
            default: w = '0;
        endcase
        w.pc_load = w.pc_we | (w.pc_we_cond & zero);
        if (rst) begin
            w.mem_rd     = 1'b0;
            w.mem_wr     = 1'b0;
            w.ir_we      = 1'b0;
            w.pc_we      = 1'b0;
            w.pc_we_cond = 1'b0;
            w.pc_load    = 1'b0;
            w.rf_we      = 1'b0;
        end
        ctl = w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_reset_quiet_r1: assert (!(ctl.mem_rd || ctl.mem_wr || ctl.ir_we || ctl.pc_we ||
                                        ctl.pc_we_cond || ctl.pc_load || ctl.rf_we));
        end
    end

    p_branch_follows_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (step == ST_BRANCH) |-> (ctl.pc_load == zero));

    p_pcload_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (step != ST_FETCH && step != ST_BRANCH) |-> !ctl.pc_load);

    p_fetch_loads_pc_r10: assert property (@(posedge clk) disable iff (rst)
        (step == ST_FETCH) |-> ctl.pc_load);

    p_rdwr_exclusive_r13: assert property (@(posedge clk) disable iff (rst)
        !(ctl.mem_rd && ctl.mem_wr));

endmodule

// File: rtl/mc_alu_decode.sv
`timescale 1ns/1ps
module mc_alu_decode
    import mc_ctrl_pkg::*;
#(
    parameter int              FN_W    = 6,
    parameter int              AC_W    = 4,
    parameter logic [FN_W-1:0] FN_ADD  = 6'h20,
    parameter logic [FN_W-1:0] FN_SUB  = 6'h22,
    parameter logic [FN_W-1:0] FN_AND  = 6'h24,
    parameter logic [FN_W-1:0] FN_OR   = 6'h25,
    parameter logic [FN_W-1:0] FN_SLT  = 6'h2A,
    parameter logic [AC_W-1:0] AC_AND  = 4'b0000,
    parameter logic [AC_W-1:0] AC_OR   = 4'b0001,
    parameter logic [AC_W-1:0] AC_ADD  = 4'b0010,
    parameter logic [AC_W-1:0] AC_SUB  = 4'b0110,
    parameter logic [AC_W-1:0] AC_SLT  = 4'b0111
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      alu_op,
    input  logic [FN_W-1:0] funct,
    output logic [AC_W-1:0] alu_ctrl
);

    always_comb begin
        case (alu_op)
            AOP_ADD: alu_ctrl = AC_ADD;
            AOP_SUB: alu_ctrl = AC_SUB;
            default: begin
                if (funct == FN_SUB)
                    alu_ctrl = AC_SUB;
                else if (funct == FN_AND)
                    alu_ctrl = AC_AND;
                else if (funct == FN_OR)
                    alu_ctrl = AC_OR;
                else if (funct == FN_SLT)
                    alu_ctrl = AC_SLT;
                else if (funct == FN_ADD)
                    alu_ctrl = AC_ADD;
                else
                    alu_ctrl = AC_ADD;
            end
        endcase
    end

    p_fixed_add_r11: assert property (@(posedge clk) disable iff (rst)
        (alu_op == AOP_ADD) |-> (alu_ctrl == AC_ADD));

    p_fixed_sub_r11: assert property (@(posedge clk) disable iff (rst)
        (alu_op == AOP_SUB) |-> (alu_ctrl == AC_SUB));

endmodule

// File: rtl/mc_ctrl_seq.sv
`timescale 1ns/1ps
module mc_ctrl_seq
    import mc_ctrl_pkg::*;
#(
    parameter int OP_W = 6,
    parameter int FN_W = 6,
    parameter int AC_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    input  logic            zero,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            addr_sel,
    output logic            ir_we,
    output logic            pc_we,
    output logic            pc_we_cond,
    output logic            pc_load,
    output logic            rf_we,
    output logic            rf_dst_sel,
    output logic            rf_wdata_sel,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_op,
    output logic            pc_src,
    output logic [AC_W-1:0] alu_ctrl
);

    cls_e  cls;
    step_e step;
    ctl_t  ctl;

    mc_op_classify #(.OP_W(OP_W)) i_classify (
        .opcode (opcode),
        .cls    (cls)
    );

    mc_seq_state i_state (
        .clk    (clk),
        .rst    (rst),
        .cls_in (cls),
        .step   (step)
    );

    mc_ctl_drive i_drive (
        .clk  (clk),
        .rst  (rst),
        .zero (zero),
        .step (step),
        .ctl  (ctl)
    );

    mc_alu_decode #(.FN_W(FN_W), .AC_W(AC_W)) i_alu_dec (
        .clk      (clk),
        .rst      (rst),
        .alu_op   (ctl.alu_op),
        .funct    (funct),
        .alu_ctrl (alu_ctrl)
    );

    assign mem_rd       = ctl.mem_rd;
    assign mem_wr       = ctl.mem_wr;
    assign addr_sel     = ctl.addr_sel;
    assign ir_we        = ctl.ir_we;
    assign pc_we        = ctl.pc_we;
    assign pc_we_cond   = ctl.pc_we_cond;
    assign pc_load      = ctl.pc_load;
    assign rf_we        = ctl.rf_we;
    assign rf_dst_sel   = ctl.rf_dst_sel;
    assign rf_wdata_sel = ctl.rf_wdata_sel;
    assign alu_a_sel    = ctl.alu_a_sel;
    assign alu_b_sel    = ctl.alu_b_sel;
    assign alu_op       = ctl.alu_op;
    assign pc_src       = ctl.pc_src;

endmodule

// File: tb/test_mc_ctrl_seq.sv
`timescale 1ns/1ps
module test_mc_ctrl_seq;

    localparam int S_F  = 0;
    localparam int S_D  = 1;
    localparam int S_A  = 2;
    localparam int S_MR = 3;
    localparam int S_LW = 4;
    localparam int S_MW = 5;
    localparam int S_RX = 6;
    localparam int S_RW = 7;
    localparam int S_BR = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic       zero = 1'b0;

    logic mem_rd, mem_wr, addr_sel, ir_we, pc_we, pc_we_cond, pc_load;
    logic rf_we, rf_dst_sel, rf_wdata_sel, alu_a_sel, pc_src;
    logic [1:0] alu_b_sel, alu_op;
    logic [3:0] alu_ctrl;

    mc_ctrl_seq i_mc_ctrl_seq (
        .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .zero(zero),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_we(ir_we),
        .pc_we(pc_we), .pc_we_cond(pc_we_cond), .pc_load(pc_load), .rf_we(rf_we),
        .rf_dst_sel(rf_dst_sel), .rf_wdata_sel(rf_wdata_sel), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src), .alu_ctrl(alu_ctrl)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    cur = S_F;
    int    plan_q[$];
    bit    checking = 1'b0;
    bit    last_none = 1'b0;
    string tag_force = "";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // word order: mem_rd mem_wr addr_sel ir_we pc_we pc_we_cond pc_load rf_we
    //             rf_dst_sel rf_wdata_sel alu_a_sel alu_b_sel[2] alu_op[2] pc_src
    function automatic logic [15:0] exp_word(input int s, input logic r, input logic z);
        logic rd = 0, wr = 0, as = 0, ir = 0, pw = 0, pc = 0, rw = 0, ds = 0, ws = 0, aa = 0, ps = 0;
        logic [1:0] bs = 2'b00, op = 2'b00;
        logic pl;
        case (s)
            S_F:  begin rd = 1; ir = 1; pw = 1; bs = 2'b01; end
            S_D:  begin bs = 2'b11; end
            S_A:  begin aa = 1; bs = 2'b10; end
            S_MR: begin rd = 1; as = 1; end
            S_LW: begin rw = 1; ws = 1; end
            S_MW: begin wr = 1; as = 1; end
            S_RX: begin aa = 1; op = 2'b10; end
            S_RW: begin rw = 1; ds = 1; end
            S_BR: begin aa = 1; op = 2'b01; pc = 1; ps = 1; end
            default: ;
        endcase
        pl = pw | (pc & z);
        if (r) begin rd = 0; wr = 0; ir = 0; pw = 0; pc = 0; pl = 0; rw = 0; end
        return {rd, wr, as, ir, pw, pc, pl, rw, ds, ws, aa, bs, op, ps};
    endfunction

    function automatic logic [3:0] exp_alu(input logic [1:0] op, input logic [5:0] f);
        if (op == 2'b00) return 4'b0010;
        if (op == 2'b01) return 4'b0110;
        case (f)
            6'h22:   return 4'b0110;
            6'h24:   return 4'b0000;
            6'h25:   return 4'b0001;
            6'h2A:   return 4'b0111;
            default: return 4'b0010;
        endcase
    endfunction

    function automatic string step_tag(input int s);
        case (s)
            S_F:        return "R2 fetch";
            S_D:        return "R3 decode";
            S_A:        return "R6 address";
            S_MR, S_LW: return "R8 load";
            S_MW:       return "R7 store";
            S_RX, S_RW: return "R4 alu-op";
            default:    return "R5 branch";
        endcase
    endfunction

    task automatic tick(input logic r, input logic [5:0] op, input logic [5:0] fn, input logic z);
        logic [15:0] ew;
        logic [15:0] aw;
        string tg;
        @(negedge clk);
        rst = r; opcode = op; funct = fn; zero = z;
        #1;
        if (checking) begin
            ew = exp_word(cur, r, z);
            aw = {mem_rd, mem_wr, addr_sel, ir_we, pc_we, pc_we_cond, pc_load, rf_we,
                  rf_dst_sel, rf_wdata_sel, alu_a_sel, alu_b_sel, alu_op, pc_src};
            if (r) tg = "R1 reset";
            else if (tag_force != "") tg = tag_force;
            else if (cur == S_F && last_none) tg = "R9 unknown-opcode";
            else tg = step_tag(cur);
            chk({tg, " control word"}, 32'(aw), 32'(ew));
            chk("R10 pc_load", 32'(pc_load), 32'(ew[9]));
            chk("R11 alu_ctrl", 32'(alu_ctrl), 32'(exp_alu(ew[2:1], fn)));
            chk("R13 rd/wr exclusive", 32'(mem_rd & mem_wr), 32'(0));
        end
        if (r) begin
            cur = S_F;
            plan_q.delete();
        end else if (cur == S_F) begin
            cur = S_D;
            last_none = 1'b0;
        end else begin
            if (cur == S_D) begin
                case (op)
                    6'h00:   plan_q = {S_RX, S_RW};
                    6'h23:   plan_q = {S_A, S_MR, S_LW};
                    6'h2B:   plan_q = {S_A, S_MW};
                    6'h04:   plan_q = {S_BR};
                    default: last_none = 1'b1;
                endcase
            end
            if (plan_q.size() == 0) cur = S_F;
            else cur = plan_q.pop_front();
        end
    endtask

    task automatic run_ins(input logic [5:0] op, input logic [5:0] fn, input logic z);
        tick(1'b0, op, fn, z);
        for (int k = 0; k < 8; k++) begin
            tick(1'b0, op, fn, z);
            if (cur == S_F) break;
        end
    endtask

    task automatic count_len(input logic [5:0] op, input int want, input string tg);
        int n = 0;
        tick(1'b0, op, 6'h20, 1'b0);
        n++;
        while (cur != S_F && n < 10) begin
            tick(1'b0, op, 6'h20, 1'b0);
            n++;
        end
        chk({tg, " cycle count"}, 32'(n), 32'(want));
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        tick(1'b1, 6'h00, 6'h00, 1'b0);
        checking = 1'b1;
        tick(1'b1, 6'h00, 6'h00, 1'b1);      // R1 reset with zero high
        tick(1'b1, 6'h23, 6'h00, 1'b0);
        // R4 alu ops with every function code, R11
        run_ins(6'h00, 6'h20, 1'b1);
        run_ins(6'h00, 6'h22, 1'b0);
        run_ins(6'h00, 6'h24, 1'b1);
        run_ins(6'h00, 6'h25, 1'b0);
        run_ins(6'h00, 6'h2A, 1'b1);
        run_ins(6'h00, 6'h3F, 1'b0);
        // R8 load, R7 store, R6 address
        run_ins(6'h23, 6'h00, 1'b0);
        run_ins(6'h2B, 6'h00, 1'b1);
        // R5 branch taken / not taken
        run_ins(6'h04, 6'h00, 1'b1);
        run_ins(6'h04, 6'h00, 1'b0);
        // R9 unknown opcodes
        run_ins(6'h08, 6'h20, 1'b1);
        run_ins(6'h3F, 6'h00, 1'b0);
        // R4 R5 R7 R8 R9 lengths
        count_len(6'h00, 4, "R4");
        count_len(6'h04, 3, "R5");
        count_len(6'h2B, 4, "R7");
        count_len(6'h23, 5, "R8");
        count_len(6'h02, 2, "R9");
        // R12 opcode changes after decode: load continues as a load
        tick(1'b0, 6'h23, 6'h00, 1'b0);
        tick(1'b0, 6'h23, 6'h00, 1'b0);
        tag_force = "R12 class latch";
        tick(1'b0, 6'h2B, 6'h00, 1'b0);
        tick(1'b0, 6'h04, 6'h00, 1'b1);
        tick(1'b0, 6'h00, 6'h22, 1'b0);
        tag_force = "";
        chk("R12 back to fetch", 32'(cur), 32'(S_F));
        // R12 store with opcode switched to load
        tick(1'b0, 6'h2B, 6'h00, 1'b0);
        tick(1'b0, 6'h2B, 6'h00, 1'b0);
        tag_force = "R12 class latch";
        tick(1'b0, 6'h23, 6'h00, 1'b0);
        tick(1'b0, 6'h23, 6'h00, 1'b0);
        tag_force = "";
        // R1 reset in the middle of a load read cycle
        tick(1'b0, 6'h23, 6'h00, 1'b0);
        tick(1'b0, 6'h23, 6'h00, 1'b0);
        tick(1'b0, 6'h23, 6'h00, 1'b0);
        tick(1'b1, 6'h23, 6'h00, 1'b1);
        run_ins(6'h00, 6'h25, 1'b1);
        // R1 reset during a store write and during a fetch with zero high
        tick(1'b0, 6'h2B, 6'h00, 1'b0);
        tick(1'b0, 6'h2B, 6'h00, 1'b0);
        tick(1'b0, 6'h2B, 6'h00, 1'b0);
        tick(1'b1, 6'h2B, 6'h00, 1'b0);
        tick(1'b1, 6'h04, 6'h00, 1'b1);
        run_ins(6'h04, 6'h00, 1'b1);
        run_ins(6'h23, 6'h00, 1'b1);
        tick(1'b0, 6'h00, 6'h00, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule